// File: doc/BRIEF.md
# Bidirectional-Port Universal Shift Register

This block is an eight-stage storage and shift register. It can hold its value, shift toward the last stage, shift toward the first stage, or capture a parallel word. A two-bit mode code picks the operation at each rising clock edge. The stages are named A (bit 0) through H (bit WIDTH-1).

The parallel word uses one shared set of bidirectional pins. For synthesis these are split into an input bus, an output bus and one common output enable. A wrapper at chip level supplies the tri-state buffer.

Serial outputs from stage A and stage H are always driven, so several registers can be chained into a longer shifter. Two active-high disable inputs turn the parallel drivers off. An active-low synchronous clear zeroes every stage.

Top module: `univ_shift_reg`

## Requirements
- R1: With mode 2'b00 and clr_n high, every stage keeps its value at the clock edge. The serial inputs and pad_in have no effect.
- R2: With mode 2'b01 and clr_n high, each stage at bit i takes the old value of bit i-1 at the clock edge, and bit 0 (stage A) takes ser_r_in.
- R3: With mode 2'b10 and clr_n high, each stage at bit i takes the old value of bit i+1 at the clock edge, and bit WIDTH-1 (stage H) takes ser_l_in.
- R4: With mode 2'b11 and clr_n high, all stages capture pad_in at the clock edge.
- R5: A clock edge with clr_n low sets all stages to zero, whatever the mode, including mode 2'b11.
- R6: pad_oe is low, combinationally, whenever mode is 2'b11, even while clr_n is low.
- R7: pad_oe is low, combinationally, whenever dis_a or dis_b is high. The disables do not change what the register stores.
- R8: When mode is not 2'b11 and both disables are low, pad_oe is high and pad_out shows the stored word.
- R9: first_q always equals stage A and last_q always equals stage H, whatever the disables and the mode.
- R10: Two instances chained through their serial pins form a 16-bit register that shifts correctly in both directions. The low part's last_q feeds the high part's ser_r_in, and the high part's first_q feeds the low part's ser_l_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Synchronous clear, active low |
| mode | input | 2 | 00 hold, 01 shift toward H, 10 shift toward A, 11 parallel load |
| dis_a | input | 1 | Parallel output disable, active high |
| dis_b | input | 1 | Parallel output disable, active high |
| ser_r_in | input | 1 | Serial data entering stage A when shifting toward H |
| ser_l_in | input | 1 | Serial data entering stage H when shifting toward A |
| pad_in | input | WIDTH | Values seen on the shared parallel pins |
| pad_out | output | WIDTH | Stored word for the shared parallel pins |
| pad_oe | output | 1 | Common drive enable for the shared parallel pins |
| first_q | output | 1 | Stage A, always driven |
| last_q | output | 1 | Stage H, always driven |

## Verification
Several functions can act in the same cycle:
- a clear and a parallel load;
- an output disable together with a shift or a load.

The bench provokes these by sweeping every combination of mode, both disables, both serial bits and clr_n from several preloaded words. In each case it judges two things. First, pad_oe is checked right after the inputs settle. Second, pad_out and the serial taps are checked after the edge against a word the bench computes from the mode rules. For the load-with-clear case the expected results are a zero word and a low enable.

// File: rtl/univ_shift_reg.sv
module univ_shift_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic [1:0]       mode,
  input  logic             dis_a,
  input  logic             dis_b,
  input  logic             ser_r_in,
  input  logic             ser_l_in,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_out,
  output logic             pad_oe,
  output logic             first_q,
  output logic             last_q
);

  localparam logic [1:0] M_HOLD = 2'b00;
  localparam logic [1:0] M_SHR  = 2'b01;
  localparam logic [1:0] M_SHL  = 2'b10;
  localparam logic [1:0] M_LOAD = 2'b11;

  logic [WIDTH-1:0] stage_q;
  logic [WIDTH-1:0] stage_d;

  always_comb begin
    case (mode)
      M_HOLD:  stage_d = stage_q;
      M_SHR:   stage_d = {stage_q[WIDTH-2:0], ser_r_in};
      M_SHL:   stage_d = {ser_l_in, stage_q[WIDTH-1:1]};
      M_LOAD:  stage_d = pad_in;
      default: stage_d = stage_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!clr_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign pad_out = stage_q;
  assign pad_oe  = (mode != M_LOAD) && !dis_a && !dis_b;
  assign first_q = stage_q[0];
  assign last_q  = stage_q[WIDTH-1];

endmodule

// File: rtl/univ_shift_reg_chk.sv
module univ_shift_reg_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             clr_n,
  input logic [1:0]       mode,
  input logic             dis_a,
  input logic             dis_b,
  input logic             ser_r_in,
  input logic             ser_l_in,
  input logic [WIDTH-1:0] pad_in,
  input logic [WIDTH-1:0] pad_out,
  input logic             pad_oe,
  input logic             first_q,
  input logic             last_q
);

  logic armed = 1'b0;
  always_ff @(posedge clk) if (!clr_n) armed <= 1'b1;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && mode == 2'b00) |=> $stable(pad_out)); // R1
  AST_SHR_STEP: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && mode == 2'b01) |=> pad_out == {$past(pad_out[WIDTH-2:0]), $past(ser_r_in)}); // R2
  AST_SHL_STEP: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && mode == 2'b10) |=> pad_out == {$past(ser_l_in), $past(pad_out[WIDTH-1:1])}); // R3
  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && mode == 2'b11) |=> pad_out == $past(pad_in)); // R4
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!armed)
    !clr_n |=> pad_out == '0); // R5
  AST_LOAD_NO_DRIVE: assert property (@(posedge clk)
    (mode == 2'b11) |-> !pad_oe); // R6
  AST_DISABLE_NO_DRIVE: assert property (@(posedge clk)
    (dis_a || dis_b) |-> !pad_oe); // R7
  AST_ENABLE_DRIVE: assert property (@(posedge clk)
    (mode != 2'b11 && !dis_a && !dis_b) |-> pad_oe); // R8
  AST_TAP_FIRST: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && mode == 2'b01) |=> first_q == $past(ser_r_in)); // R9
  AST_TAP_LAST: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && mode == 2'b10) |=> last_q == $past(ser_l_in)); // R9

endmodule

bind univ_shift_reg univ_shift_reg_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/tb_univ_shift_reg.sv
module tb_univ_shift_reg;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic       clr_n = 1'b1;
  logic [1:0] mode = 2'b00;
  logic       dis_a = 1'b0, dis_b = 1'b0, sr = 1'b0, sl = 1'b0;
  logic [7:0] pin = '0;
  logic [7:0] pout;
  logic       poe, fq, lq;

  univ_shift_reg #(.WIDTH(8)) dut (
    .clk(clk), .clr_n(clr_n), .mode(mode), .dis_a(dis_a), .dis_b(dis_b),
    .ser_r_in(sr), .ser_l_in(sl), .pad_in(pin), .pad_out(pout),
    .pad_oe(poe), .first_q(fq), .last_q(lq));

  logic       c_clr = 1'b1;
  logic [1:0] c_mode = 2'b00;
  logic       c_sr = 1'b0, c_sl = 1'b0;
  logic [15:0] c_pin = '0;
  logic [7:0] lo_out, hi_out;
  logic       lo_oe, hi_oe, lo_f, lo_l, hi_f, hi_l;

  univ_shift_reg #(.WIDTH(8)) lo (
    .clk(clk), .clr_n(c_clr), .mode(c_mode), .dis_a(1'b0), .dis_b(1'b0),
    .ser_r_in(c_sr), .ser_l_in(hi_f), .pad_in(c_pin[7:0]), .pad_out(lo_out),
    .pad_oe(lo_oe), .first_q(lo_f), .last_q(lo_l));

  univ_shift_reg #(.WIDTH(8)) hi (
    .clk(clk), .clr_n(c_clr), .mode(c_mode), .dis_a(1'b0), .dis_b(1'b0),
    .ser_r_in(lo_l), .ser_l_in(c_sl), .pad_in(c_pin[15:8]), .pad_out(hi_out),
    .pad_oe(hi_oe), .first_q(hi_f), .last_q(hi_l));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] nxt8(input logic [7:0] q, input logic [1:0] m,
                                      input logic c, input logic r, input logic l,
                                      input logic [7:0] p);
    if (!c) return 8'd0;
    case (m)
      2'd0: return q;
      2'd1: return (q << 1) | {7'd0, r};
      2'd2: return (q >> 1) | {l, 7'd0};
      default: return p;
    endcase
  endfunction

  function automatic logic [15:0] nxt16(input logic [15:0] q, input logic [1:0] m,
                                        input logic c, input logic r, input logic l,
                                        input logic [15:0] p);
    if (!c) return 16'd0;
    case (m)
      2'd0: return q;
      2'd1: return (q << 1) | {15'd0, r};
      2'd2: return (q >> 1) | {l, 15'd0};
      default: return p;
    endcase
  endfunction

  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] vals [5];
    logic [15:0] m16;
    logic [15:0] lfsr;
    vals[0] = 8'hA5; vals[1] = 8'h3C; vals[2] = 8'h81; vals[3] = 8'hFF; vals[4] = 8'h00;

    // reset state: clear then check zero, enabled, taps (R5, R8, R9)
    clr_n = 1'b0; c_clr = 1'b0;
    tick();
    chk("R5 reset", {24'd0, pout}, 32'd0);
    chk("R8 reset oe", {31'd0, poe}, 32'd1);
    chk("R9 reset taps", {30'd0, fq, lq}, 32'd0);
    clr_n = 1'b1; c_clr = 1'b1;

    for (int vi = 0; vi < 5; vi++) begin
      for (int m = 0; m < 4; m++) begin
        for (int d = 0; d < 4; d++) begin
          for (int s = 0; s < 4; s++) begin
            for (int c = 0; c < 2; c++) begin
              logic [7:0] v, p, e;
              string req;
              v = vals[vi];
              p = {v[3:0], v[7:4]} ^ 8'h66;
              clr_n = 1'b1; mode = 2'b11; dis_a = 1'b0; dis_b = 1'b0; pin = v;
              tick();
              clr_n = c[0]; mode = m[1:0]; dis_a = d[0]; dis_b = d[1];
              sr = s[0]; sl = s[1]; pin = p;
              #1;
              if (m == 3)      chk("R6 oe in load", {31'd0, poe}, 32'd0);
              else if (d != 0) chk("R7 oe disabled", {31'd0, poe}, 32'd0);
              else             chk("R8 oe enabled", {31'd0, poe}, 32'd1);
              e = nxt8(v, m[1:0], c[0], s[0], s[1], p);
              tick();
              if (c == 0)      req = "R5 clear";
              else if (m == 0) req = "R1 hold";
              else if (m == 1) req = "R2 shift right";
              else if (m == 2) req = "R3 shift left";
              else             req = "R4 load";
              if (d != 0) req = {req, " (R7 disable no effect)"};
              chk(req, {24'd0, pout}, {24'd0, e});
              chk("R9 taps", {30'd0, fq, lq}, {30'd0, e[0], e[7]});
            end
          end
        end
      end
    end

    // cascade of two instances into a 16-bit shifter (R10)
    c_clr = 1'b0; c_mode = 2'b00;
    tick();
    m16 = 16'd0;
    c_clr = 1'b1;
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      c_clr = (lfsr[7:3] != 5'd0);
      if (lfsr[12:10] == 3'd0) c_mode = 2'b11;
      else if (lfsr[12:10] == 3'd1) c_mode = 2'b00;
      else c_mode = lfsr[0] ? 2'b01 : 2'b10;
      c_sr = lfsr[5]; c_sl = lfsr[9];
      c_pin = lfsr ^ 16'h5A3C;
      m16 = nxt16(m16, c_mode, c_clr, c_sr, c_sl, c_pin);
      tick();
      chk("R10 cascade", {16'd0, hi_out, lo_out}, {16'd0, m16});
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule